// File: doc/BRIEF.md
# Indexed Register Port with Interrupt Status

This block fronts a 128-byte space of control registers and battery-style RAM through only two bus addresses. Software first writes a byte offset to the even address, and then reads or writes the selected byte through the odd address. Most offsets are plain storage. Four offsets have special behaviour:

- two writable control bytes (`ctl_a`, `ctl_b`),
- a status byte that clears when it is read (`stat`),
- a constant validity byte.

The status byte gathers three event flags: update, alarm and periodic. The flags arrive as pulses from time-keeping logic outside this block. The status byte also holds a summary flag, which is driven from the per-event enables in `ctl_b`. That summary flag drives the interrupt pin. A write that turns on an enable whose flag is already pending raises the interrupt at once. The read that clears the status byte also drops the interrupt.

Two reset levels exist:

- An asynchronous power-on reset loads fixed defaults.
- A synchronous functional reset clears the periodic, alarm and square-wave enables, clears the status byte and lowers the interrupt.

The functional reset also clears the shutdown-status byte at offset 0x0F. It leaves that byte alone if it holds the resume marker 0xFE. A suspend request writes that marker. The shutdown byte is also visible on its own output.

Top module: `idxreg_port`

## Requirements
- R1: A write strobe with `bus_addr_i`=0 stores `bus_wdata_i[6:0]` as the index, and bit 7 is dropped. The index changes on no other strobe. A read strobe with `bus_addr_i`=0 returns 0xFF on `bus_rdata_o` in the next cycle.
- R2: An odd-address write to any index outside 0x0A..0x0D stores the byte. An odd-address read returns it on `bus_rdata_o` one cycle after the strobe. These bytes survive the functional reset (0x0F excepted, see R9).
- R3: After power-on reset the special registers hold these values: 0x0A = 0x26, 0x0B = 0x02, 0x0C = 0x00 and 0x0D = 0x80. Every other byte is 0x00, the index is 0 and `irq_o` is low.
- R4: Odd-address writes to index 0x0C (status) and 0x0D (validity) change nothing. Index 0x0D always reads 0x80.
- R5: An odd-address read of index 0x0C returns the status byte as it was before the strobe. From the next cycle the status byte is 0x00 and `irq_o` is low, unless R10 applies.
- R6: An `evt_i` pulse sets one status flag in the next cycle, as follows:
  - bit 0 sets 0x0C bit 4 (update),
  - bit 1 sets bit 5 (alarm),
  - bit 2 sets bit 6 (periodic).

  If the flag was clear and its enable is 1, the summary flag (0x0C bit 7) and `irq_o` rise in the same cycle. The enables are 0x0B bit 4, bit 5 and bit 6 for the same three events.
- R7: A write to index 0x0B compares the written bits 6:4 with the status flags. If any enabled flag is pending, the summary flag and `irq_o` are 1 from the next cycle. Otherwise both are cleared.
- R8: The functional reset `rst_i` clears 0x0B bits 6, 5 and 3 and keeps its other bits. It wins over a same-cycle write. It clears the status byte and lowers `irq_o`. It leaves index 0x0A unchanged.
- R9: `rst_i` clears byte 0x0F unless it holds 0xFE. `suspend_i` loads 0xFE into byte 0x0F, and it wins over a same-cycle write or reset. `shutdown_o` always shows byte 0x0F.
- R10: An event that arrives in the same cycle as a status read is not lost. The read returns the older contents. Afterwards the status byte holds the new flag, and holds the summary flag as well if that event is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_i | input | 1 | Synchronous functional reset, active high |
| suspend_i | input | 1 | Suspend request, writes the resume marker |
| bus_addr_i | input | 1 | Bus address bit: 0 = index, 1 = data |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after the strobe |
| evt_i | input | 3 | Event pulses: bit 0 update, bit 1 alarm, bit 2 periodic |
| irq_o | output | 1 | Interrupt request, active high |
| shutdown_o | output | 8 | Current shutdown-status byte |

## Verification
The status read and a new event pulse can land in the same cycle. If the clear were to win, an interrupt would be lost.

The bench holds an alarm flag pending with only the update interrupt enabled. It then strobes the status read and pulses the update event together. It expects three results:
- the read returns only the old alarm flag,
- `irq_o` is high right after,
- a second read returns the update flag with the summary bit.

The suspend request is also driven in the same cycle as a data write to the shutdown byte, and the marker must win.

// File: rtl/idxreg_pkg.sv
package idxreg_pkg;

   // Bit positions that software decodes in the control and status bytes.
   localparam int CTLB_SQW  = 3;   // square-wave enable
   localparam int CTLB_UPD  = 4;   // update interrupt enable
   localparam int CTLB_ALM  = 5;   // alarm interrupt enable
   localparam int CTLB_PER  = 6;   // periodic interrupt enable
   localparam int STAT_IRQF = 7;   // summary flag
   localparam int STAT_LSB  = 4;   // first event flag in the status byte
   localparam int N_EVT     = 3;   // update, alarm, periodic

   typedef enum logic [1:0] {
      EVT_UPD = 2'd0,
      EVT_ALM = 2'd1,
      EVT_PER = 2'd2
   } evt_e;

   // Functional reset clears these control-B enables.
   localparam logic [7:0] CTLB_RST_CLR =
      8'((1 << CTLB_PER) | (1 << CTLB_ALM) | (1 << CTLB_SQW));

endpackage

// File: rtl/idxreg_ctrl.sv
module idxreg_ctrl #(
   parameter int                DATA_W  = 8,
   parameter logic [DATA_W-1:0] A_INIT  = 8'h26,
   parameter logic [DATA_W-1:0] B_INIT  = 8'h02,
   parameter logic [DATA_W-1:0] B_CLR   = 8'h68
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_i,
   input  logic              wr_a_i,
   input  logic              wr_b_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] a_o,
   output logic [DATA_W-1:0] b_o
);

   if (DATA_W < 8) begin : g_chk_w
      $error("idxreg_ctrl: DATA_W must be at least 8");
   end

   logic [DATA_W-1:0] a_q, b_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         a_q <= A_INIT;
      end else if (wr_a_i) begin
         a_q <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         b_q <= B_INIT;
      end else if (rst_i) begin
         b_q <= b_q & ~B_CLR;
      end else if (wr_b_i) begin
         b_q <= wdata_i;
      end
   end

   assign a_o = a_q;
   assign b_o = b_q;

   AST_B_RST_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
      rst_i |=> ((b_q & B_CLR) == '0)); // R8
   AST_A_RST_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      (rst_i && !wr_a_i) |=> $stable(a_q)); // R8

endmodule

// File: rtl/idxreg_status.sv
module idxreg_status #(
   parameter int DATA_W   = 8,
   parameter int NFLG     = 3,
   parameter int FLG_LSB  = 4,
   parameter int IRQF_BIT = 7
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_i,
   input  logic              rd_clr_i,
   input  logic              bwr_i,
   input  logic [NFLG-1:0]   bwr_en_i,
   input  logic [NFLG-1:0]   en_i,
   input  logic [NFLG-1:0]   evt_i,
   output logic [DATA_W-1:0] stat_o,
   output logic              irq_o
);

   if (FLG_LSB + NFLG > IRQF_BIT || IRQF_BIT >= DATA_W) begin : g_chk_pos
      $error("idxreg_status: flag field overlaps the summary bit");
   end

   logic [NFLG-1:0] flg_q, flg_base, flg_fresh, flg_d;
   logic            irqf_q, irqf_base, irqf_d, irq_q;

   // A read clears first, then same-cycle events land on the cleared byte.
   always_comb begin
      flg_base  = rd_clr_i ? '0 : flg_q;
      irqf_base = rd_clr_i ? 1'b0 : irqf_q;
      flg_fresh = evt_i & ~flg_base;
      flg_d     = flg_base | evt_i;
      if (bwr_i) begin
         irqf_d = |(bwr_en_i & flg_d);
      end else begin
         irqf_d = irqf_base | (|(flg_fresh & en_i));
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         flg_q  <= '0;
         irqf_q <= 1'b0;
         irq_q  <= 1'b0;
      end else if (rst_i) begin
         flg_q  <= '0;
         irqf_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         flg_q  <= flg_d;
         irqf_q <= irqf_d;
         irq_q  <= irqf_d;
      end
   end

   always_comb begin
      stat_o                    = '0;
      stat_o[FLG_LSB +: NFLG]   = flg_q;
      stat_o[IRQF_BIT]          = irqf_q;
   end

   assign irq_o = irq_q;

   AST_IRQ_PIN_MATCH: assert property (@(posedge clk) disable iff (!por_n)
      irq_q == irqf_q); // R6
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
      (rd_clr_i && !rst_i && evt_i == '0 && !bwr_i) |=> (stat_o == '0 && !irq_o)); // R5
   AST_EVT_LANDS: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_i && |evt_i) |=> ((flg_q & $past(evt_i)) == $past(evt_i))); // R10
   AST_RST_QUIET: assert property (@(posedge clk) disable iff (!por_n)
      rst_i |=> (!irq_o && flg_q == '0)); // R8
   AST_ENABLE_RAISE: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_i && bwr_i && |(bwr_en_i & (flg_q | evt_i)) && !rd_clr_i) |=> irq_o); // R7

endmodule

// File: rtl/idxreg_ram.sv
module idxreg_ram #(
   parameter int                IDX_W    = 7,
   parameter int                DATA_W   = 8,
   parameter int                HOLE_LO  = 10,
   parameter int                HOLE_HI  = 13,
   parameter int                SHUT_IDX = 15,
   parameter logic [DATA_W-1:0] MARK     = 8'hFE
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_i,
   input  logic              susp_i,
   input  logic              wr_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [DATA_W-1:0] shut_o
);

   localparam int DEPTH = 1 << IDX_W;

   if (SHUT_IDX >= DEPTH || (SHUT_IDX >= HOLE_LO && SHUT_IDX <= HOLE_HI)) begin : g_chk_shut
      $error("idxreg_ram: shutdown byte index is out of range or in the register hole");
   end

   logic [DEPTH-1:0][DATA_W-1:0] cells;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      if (g >= HOLE_LO && g <= HOLE_HI) begin : g_hole
         // Special registers live elsewhere; no storage here.
         assign cells[g] = '0;
      end else if (g == SHUT_IDX) begin : g_shut
         logic [DATA_W-1:0] cell_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               cell_q <= '0;
            end else if (susp_i) begin
               cell_q <= MARK;
            end else if (rst_i) begin
               if (cell_q != MARK) begin
                  cell_q <= '0;
               end
            end else if (wr_i && idx_i == IDX_W'(g)) begin
               cell_q <= wdata_i;
            end
         end
         assign cells[g] = cell_q;
      end else begin : g_plain
         logic [DATA_W-1:0] cell_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               cell_q <= '0;
            end else if (wr_i && idx_i == IDX_W'(g)) begin
               cell_q <= wdata_i;
            end
         end
         assign cells[g] = cell_q;
      end
   end

   assign rdata_o = cells[idx_i];
   assign shut_o  = cells[SHUT_IDX];

   AST_SUSPEND_MARK: assert property (@(posedge clk) disable iff (!por_n)
      susp_i |=> (shut_o == MARK)); // R9
   AST_MARK_SURVIVES: assert property (@(posedge clk) disable iff (!por_n)
      (rst_i && shut_o == MARK) |=> (shut_o == MARK)); // R9
   AST_SHUT_RST_CLR: assert property (@(posedge clk) disable iff (!por_n)
      (rst_i && !susp_i && shut_o != MARK) |=> (shut_o == '0)); // R9

endmodule

// File: rtl/idxreg_port.sv
module idxreg_port
   import idxreg_pkg::*;
#(
   parameter int         IDX_W    = 7,
   parameter int         DATA_W   = 8,
   parameter int         A_IDX    = 10,
   parameter int         SHUT_IDX = 15,
   parameter logic [7:0] A_INIT   = 8'h26,
   parameter logic [7:0] B_INIT   = 8'h02,
   parameter logic [7:0] D_VAL    = 8'h80,
   parameter logic [7:0] MARK     = 8'hFE
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_i,
   input  logic              suspend_i,
   input  logic              bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic [N_EVT-1:0]  evt_i,
   output logic              irq_o,
   output logic [DATA_W-1:0] shutdown_o
);

   localparam int               B_IDX = A_IDX + 1;
   localparam int               C_IDX = A_IDX + 2;
   localparam int               D_IDX = A_IDX + 3;
   localparam logic [IDX_W-1:0] SEL_A = IDX_W'(A_IDX);
   localparam logic [IDX_W-1:0] SEL_B = IDX_W'(B_IDX);
   localparam logic [IDX_W-1:0] SEL_C = IDX_W'(C_IDX);
   localparam logic [IDX_W-1:0] SEL_D = IDX_W'(D_IDX);

   if (DATA_W != 8) begin : g_chk_data
      $error("idxreg_port: the register layout assumes byte-wide data");
   end
   if (IDX_W >= DATA_W || D_IDX >= (1 << IDX_W)) begin : g_chk_idx
      $error("idxreg_port: index width does not fit the register block");
   end

   logic [IDX_W-1:0]  idx_q;
   logic              idx_wr, data_wr, data_rd;
   logic              sel_a, sel_b, sel_c, sel_d;
   logic [DATA_W-1:0] a_val, b_val, stat_val, ram_val, rd_mux, rdata_q;

   assign idx_wr  = bus_wr_i && !bus_addr_i;
   assign data_wr = bus_wr_i && bus_addr_i;
   assign data_rd = bus_rd_i && bus_addr_i;
   assign sel_a   = (idx_q == SEL_A);
   assign sel_b   = (idx_q == SEL_B);
   assign sel_c   = (idx_q == SEL_C);
   assign sel_d   = (idx_q == SEL_D);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         idx_q <= '0;
      end else if (idx_wr) begin
         idx_q <= bus_wdata_i[IDX_W-1:0];
      end
   end

   idxreg_ctrl #(
      .DATA_W (DATA_W),
      .A_INIT (A_INIT),
      .B_INIT (B_INIT),
      .B_CLR  (CTLB_RST_CLR)
   ) u_ctrl (
      .clk     (clk),
      .por_n   (por_n),
      .rst_i   (rst_i),
      .wr_a_i  (data_wr && sel_a),
      .wr_b_i  (data_wr && sel_b),
      .wdata_i (bus_wdata_i),
      .a_o     (a_val),
      .b_o     (b_val)
   );

   idxreg_status #(
      .DATA_W   (DATA_W),
      .NFLG     (N_EVT),
      .FLG_LSB  (STAT_LSB),
      .IRQF_BIT (STAT_IRQF)
   ) u_status (
      .clk      (clk),
      .por_n    (por_n),
      .rst_i    (rst_i),
      .rd_clr_i (data_rd && sel_c),
      .bwr_i    (data_wr && sel_b),
      .bwr_en_i (bus_wdata_i[CTLB_UPD +: N_EVT]),
      .en_i     (b_val[CTLB_UPD +: N_EVT]),
      .evt_i    (evt_i),
      .stat_o   (stat_val),
      .irq_o    (irq_o)
   );

   idxreg_ram #(
      .IDX_W    (IDX_W),
      .DATA_W   (DATA_W),
      .HOLE_LO  (A_IDX),
      .HOLE_HI  (D_IDX),
      .SHUT_IDX (SHUT_IDX),
      .MARK     (MARK)
   ) u_ram (
      .clk     (clk),
      .por_n   (por_n),
      .rst_i   (rst_i),
      .susp_i  (suspend_i),
      .wr_i    (data_wr),
      .idx_i   (idx_q),
      .wdata_i (bus_wdata_i),
      .rdata_o (ram_val),
      .shut_o  (shutdown_o)
   );

   always_comb begin
      if (!bus_addr_i) begin
         rd_mux = '1;
      end else if (sel_a) begin
         rd_mux = a_val;
      end else if (sel_b) begin
         rd_mux = b_val;
      end else if (sel_c) begin
         rd_mux = stat_val;
      end else if (sel_d) begin
         rd_mux = D_VAL;
      end else begin
         rd_mux = ram_val;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rdata_q <= '0;
      end else if (bus_rd_i) begin
         rdata_q <= rd_mux;
      end
   end

   assign bus_rdata_o = rdata_q;

   AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      !idx_wr |=> $stable(idx_q)); // R1
   AST_EVEN_READ_ONES: assert property (@(posedge clk) disable iff (!por_n)
      (bus_rd_i && !bus_addr_i) |=> (bus_rdata_o == '1)); // R1
   AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
      (data_wr && sel_c && !rst_i && evt_i == '0) |=> $stable(stat_val)); // R4

endmodule

// File: tb/idxreg_port_bench.sv
`timescale 1ns/1ps
module idxreg_port_bench;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       rst_i = 1'b0;
   logic       suspend_i = 1'b0;
   logic       bus_addr_i = 1'b0;
   logic       bus_wr_i = 1'b0;
   logic       bus_rd_i = 1'b0;
   logic [7:0] bus_wdata_i = 8'h00;
   logic [7:0] bus_rdata_o;
   logic [2:0] evt_i = 3'b000;
   logic       irq_o;
   logic [7:0] shutdown_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit rd_seen = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   idxreg_port u_idxreg_port (
      .clk         (clk),
      .por_n       (por_n),
      .rst_i       (rst_i),
      .suspend_i   (suspend_i),
      .bus_addr_i  (bus_addr_i),
      .bus_wr_i    (bus_wr_i),
      .bus_rd_i    (bus_rd_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .evt_i       (evt_i),
      .irq_o       (irq_o),
      .shutdown_o  (shutdown_o)
   );

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // Monitor: a read strobe seen at a rising edge yields data checked at the next falling edge.
   always @(posedge clk) rd_seen <= bus_rd_i;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard actual=%02h expected=none", bus_rdata_o);
         end else begin
            chk(tag_q.pop_front(), bus_rdata_o, exp_q.pop_front());
         end
      end
   end

   task automatic wr_bus(logic a, logic [7:0] d);
      @(negedge clk);
      bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
      @(negedge clk);
      bus_wr_i = 1'b0;
   endtask

   task automatic rd_bus(logic a, logic [7:0] exp, string tag);
      @(negedge clk);
      bus_addr_i = a; bus_rd_i = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      bus_rd_i = 1'b0;
   endtask

   task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
      wr_bus(1'b0, idx);
      wr_bus(1'b1, d);
   endtask

   task automatic reg_rd(logic [7:0] idx, logic [7:0] exp, string tag);
      wr_bus(1'b0, idx);
      rd_bus(1'b1, exp, tag);
   endtask

   task automatic pulse_evt(logic [2:0] e);
      @(negedge clk);
      evt_i = e;
      @(negedge clk);
      evt_i = 3'b000;
   endtask

   task automatic pulse_rst();
      @(negedge clk);
      rst_i = 1'b1;
      @(negedge clk);
      rst_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);

      // R3 power-on state
      chk("R3 irq after power-on", {7'h0, irq_o}, 8'h00);
      chk("R3 shutdown after power-on", shutdown_o, 8'h00);
      reg_rd(8'h0A, 8'h26, "R3 ctl A default");
      reg_rd(8'h0B, 8'h02, "R3 ctl B default");
      reg_rd(8'h0C, 8'h00, "R3 status default");
      reg_rd(8'h0D, 8'h80, "R3 validity default");
      reg_rd(8'h20, 8'h00, "R3 RAM byte default");

      // R1 index port
      rd_bus(1'b0, 8'hFF, "R1 even read");
      wr_bus(1'b0, 8'h8A);
      rd_bus(1'b1, 8'h26, "R1 index bit7 dropped");

      // R2 plain RAM
      reg_wr(8'h20, 8'h5A);
      reg_wr(8'h7F, 8'hA5);
      reg_wr(8'h0E, 8'h33);
      reg_rd(8'h20, 8'h5A, "R2 RAM 0x20");
      reg_rd(8'h7F, 8'hA5, "R2 RAM 0x7F");
      reg_rd(8'h0E, 8'h33, "R2 RAM 0x0E");

      // R4 read-only bytes
      reg_wr(8'h0C, 8'hFF);
      reg_wr(8'h0D, 8'h00);
      chk("R4 irq after status write", {7'h0, irq_o}, 8'h00);
      reg_rd(8'h0C, 8'h00, "R4 status write ignored");
      reg_rd(8'h0D, 8'h80, "R4 validity write ignored");

      // R6 flags, without and with enable; R5 read clears
      reg_wr(8'h0B, 8'h02);
      pulse_evt(3'b001);
      chk("R6 disabled update keeps irq low", {7'h0, irq_o}, 8'h00);
      reg_rd(8'h0C, 8'h10, "R6 update flag without summary");
      reg_wr(8'h0B, 8'h12);
      pulse_evt(3'b001);
      chk("R6 enabled update raises irq", {7'h0, irq_o}, 8'h01);
      reg_rd(8'h0C, 8'h90, "R6 update flag with summary");
      chk("R5 irq low after status read", {7'h0, irq_o}, 8'h00);
      reg_rd(8'h0C, 8'h00, "R5 status cleared by read");
      reg_wr(8'h0B, 8'h42);
      pulse_evt(3'b100);
      reg_rd(8'h0C, 8'hC0, "R6 periodic flag with summary");
      reg_wr(8'h0B, 8'h22);
      pulse_evt(3'b010);
      reg_rd(8'h0C, 8'hA0, "R6 alarm flag with summary");

      // R7 enabling a pending flag
      reg_wr(8'h0B, 8'h02);
      pulse_evt(3'b010);
      chk("R7 pending alarm, irq low", {7'h0, irq_o}, 8'h00);
      reg_wr(8'h0B, 8'h22);
      chk("R7 enable on pending raises irq", {7'h0, irq_o}, 8'h01);
      reg_wr(8'h0B, 8'h12);
      chk("R7 non-matching enable lowers irq", {7'h0, irq_o}, 8'h00);
      reg_rd(8'h0C, 8'h20, "R7 summary cleared, flag kept");

      // R10 event in the same cycle as a status read
      reg_wr(8'h0B, 8'h12);
      pulse_evt(3'b010);
      wr_bus(1'b0, 8'h0C);
      @(negedge clk);
      bus_addr_i = 1'b1; bus_rd_i = 1'b1; evt_i = 3'b001;
      exp_q.push_back(8'h20); tag_q.push_back("R10 read returns old flags");
      @(negedge clk);
      bus_rd_i = 1'b0; evt_i = 3'b000;
      chk("R10 irq raised by concurrent event", {7'h0, irq_o}, 8'h01);
      reg_rd(8'h0C, 8'h90, "R10 concurrent event kept");

      // R8 functional reset
      reg_wr(8'h0A, 8'h2F);
      reg_wr(8'h0B, 8'h7F);
      pulse_evt(3'b100);
      chk("R8 irq high before reset", {7'h0, irq_o}, 8'h01);
      pulse_rst();
      chk("R8 irq low after reset", {7'h0, irq_o}, 8'h00);
      reg_rd(8'h0B, 8'h17, "R8 enables cleared in ctl B");
      reg_rd(8'h0C, 8'h00, "R8 status cleared");
      reg_rd(8'h0A, 8'h2F, "R8 ctl A kept");
      reg_rd(8'h20, 8'h5A, "R2 RAM survives reset");

      // R9 shutdown byte
      reg_wr(8'h0F, 8'h55);
      chk("R9 shutdown output follows write", shutdown_o, 8'h55);
      pulse_rst();
      chk("R9 reset clears shutdown byte", shutdown_o, 8'h00);
      reg_rd(8'h0F, 8'h00, "R9 cleared byte reads zero");
      reg_wr(8'h0F, 8'h12);
      @(negedge clk); suspend_i = 1'b1;
      @(negedge clk); suspend_i = 1'b0;
      chk("R9 suspend writes marker", shutdown_o, 8'hFE);
      pulse_rst();
      chk("R9 marker survives reset", shutdown_o, 8'hFE);
      reg_rd(8'h0F, 8'hFE, "R9 marker readable");
      reg_wr(8'h0F, 8'h00);
      chk("R9 plain write to shutdown byte", shutdown_o, 8'h00);
      @(negedge clk);
      bus_addr_i = 1'b1; bus_wdata_i = 8'h77; bus_wr_i = 1'b1; suspend_i = 1'b1;
      @(negedge clk);
      bus_wr_i = 1'b0; suspend_i = 1'b0;
      chk("R9 suspend wins over write", shutdown_o, 8'hFE);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_chk++;
         n_fail++;
         $display("FAIL scoreboard actual=%0d pending expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule